// File: doc/BRIEF.md
# Block Address Translation Matcher

This block translates a 32-bit effective address through a small set of programmable block-mapping entries. Each entry is a pair of words: an upper word that names an effective block, its length and which privilege levels may use it, and a lower word that gives the physical block base and the access rights. A lookup compares the address against every entry of the selected bank in parallel. The lowest-indexed usable match supplies the physical address and the read/write verdict.

Two independent banks exist, one for instruction fetches and one for all other accesses. Each bank holds the same number of entries. A simple write port loads any word of any entry. All entries reset to zero, which makes them unusable. Block length is variable: a mask field in the upper word picks which effective-address bits in the middle range pass through to the physical address and which come from the physical block base. The smallest block is 128 KB and the largest is 256 MB. The result is registered by default, so it appears one clock after the request.

Top module: `bat_xlate`

## Requirements
- R1: When several entries of the selected bank match, the entry with the lowest index supplies the result.
- R2: An entry matches only if effective-address bits 31:28 equal upper-word bits 31:28 exactly.
- R3: Upper-word bits 12:2 form an 11-bit length mask aligned to address bits 27:17. Address bits 27:17 with the masked positions cleared must equal upper-word bits 27:17. A mask of zero gives a 128 KB block and a mask of all ones gives a 256 MB block.
- R4: An entry is usable in supervisor mode only if upper-word bit 1 is set, and in user mode only if upper-word bit 0 is set. An unusable entry never matches.
- R5: On a hit, the physical address is built from three parts. Bits 31:28 are lower-word bits 31:28. Bits 27:17 are (address bits 27:17 AND mask) OR lower-word bits 27:17. Bits 16:0 are copied from the address.
- R6: Lower-word bits 1:0 set the rights. If bit 1 is set the block is read/write. If only bit 0 is set it is read-only. If both are clear it allows no access. The rights are reported on rd_ok_o and wr_ok_o.
- R7: A store to a read-only block, or any access to a no-access block, reports hit_o=1 with prot_fault_o=1. Any other hit reports prot_fault_o=0.
- R8: ifetch_i=1 looks up the instruction bank and ifetch_i=0 looks up the data bank. A write with cfg_we_i=1 targets the instruction bank if cfg_bank_i=1 and the data bank if it is 0. It writes entry cfg_idx_i, and the upper word if cfg_upper_i=1, otherwise the lower word.
- R9: After reset every entry in both banks is zero, and all outputs are zero.
- R10: On a miss, hit_o, pa_o, rd_ok_o, wr_ok_o and prot_fault_o are all zero.
- R11: With output registering enabled (the default), the outputs reflect the request presented one clock earlier. That lookup uses the entry contents held before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ea_i | input | 32 | Effective address to translate |
| supervisor_i | input | 1 | 1 = supervisor mode, 0 = user mode |
| ifetch_i | input | 1 | 1 = instruction fetch (instruction bank), 0 = data access |
| store_i | input | 1 | 1 = write request, 0 = read request |
| cfg_we_i | input | 1 | Entry word write enable |
| cfg_bank_i | input | 1 | Bank written: 1 = instruction, 0 = data |
| cfg_idx_i | input | 2 | Entry index written |
| cfg_upper_i | input | 1 | 1 = write upper word, 0 = write lower word |
| cfg_wdata_i | input | 32 | Word to write |
| hit_o | output | 1 | A usable entry matched |
| pa_o | output | 32 | Translated physical address (zero on miss) |
| rd_ok_o | output | 1 | Block permits reads |
| wr_ok_o | output | 1 | Block permits writes |
| prot_fault_o | output | 1 | Hit, but the requested access is not permitted |

## Verification
A corrupted entry word or a wrong bank selection shows up at the ports on the first lookup that touches that entry. It appears one clock after the request as a wrong hit flag, a wrong physical address field or a wrong rights verdict. A broken priority chain only shows when two entries overlap, so the bench builds overlapping entries and pairs them with a privilege level that disables the lower-indexed one. The bench also drives lookups in the same cycle as writes, which exposes any forwarding of a new word into the lookup of that same cycle.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int unsigned EA_W    = 32;
  localparam int unsigned TOP_HI  = 31;
  localparam int unsigned TOP_LO  = 28;
  localparam int unsigned MID_HI  = 27;
  localparam int unsigned MID_LO  = 17;
  localparam int unsigned MID_W   = MID_HI - MID_LO + 1;
  localparam int unsigned MSK_LO  = 2;
  localparam int unsigned MSK_HI  = MSK_LO + MID_W - 1;
  localparam int unsigned VS_BIT  = 1;
  localparam int unsigned VP_BIT  = 0;
  localparam int unsigned RW_BIT  = 1;
  localparam int unsigned RO_BIT  = 0;

  typedef logic [EA_W-1:0] word_t;

  typedef struct packed {
    logic  hit;
    word_t pa;
    logic  rd_ok;
    logic  wr_ok;
    logic  fault;
  } xlate_res_t;
endpackage

// File: rtl/bat_regfile.sv
module bat_regfile
  import bat_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 4,
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic                         wr_bank_i,
  input  logic [IDX_W-1:0]             wr_idx_i,
  input  logic                         wr_upper_i,
  input  word_t                        wdata_i,
  input  logic                         rd_bank_i,
  output word_t [NUM_ENTRIES-1:0]      upper_o,
  output word_t [NUM_ENTRIES-1:0]      lower_o
);
  localparam int unsigned NUM_BANKS = 2;

  word_t [NUM_BANKS-1:0][NUM_ENTRIES-1:0] upr_q;
  word_t [NUM_BANKS-1:0][NUM_ENTRIES-1:0] lwr_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
      logic sel;
      assign sel = we_i && (wr_bank_i == 1'(b)) && (wr_idx_i == IDX_W'(e));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          upr_q[b][e] <= '0;
          lwr_q[b][e] <= '0;
        end else if (sel) begin
          if (wr_upper_i) upr_q[b][e] <= wdata_i;
          else            lwr_q[b][e] <= wdata_i;
        end
      end
    end
  end

  assign upper_o = upr_q[rd_bank_i];
  assign lower_o = lwr_q[rd_bank_i];
endmodule

// File: rtl/bat_entry_cmp.sv
module bat_entry_cmp
  import bat_pkg::*;
(
  input  word_t ea_i,
  input  logic  supervisor_i,
  input  word_t upper_i,
  input  word_t lower_i,
  output logic  match_o,
  output word_t pa_o,
  output logic  rd_ok_o,
  output logic  wr_ok_o
);
  logic [MID_W-1:0] len_mask;
  logic [MID_W-1:0] ea_mid;
  logic             top_eq;
  logic             mid_eq;
  logic             usable;
  logic             unused_bits;

  assign len_mask = upper_i[MSK_HI:MSK_LO];
  assign ea_mid   = ea_i[MID_HI:MID_LO];
  assign top_eq   = ea_i[TOP_HI:TOP_LO] == upper_i[TOP_HI:TOP_LO];
  // bits under the mask must be clear in the upper word for a match
  assign mid_eq   = (ea_mid & ~len_mask) == upper_i[MID_HI:MID_LO];
  assign usable   = supervisor_i ? upper_i[VS_BIT] : upper_i[VP_BIT];
  assign match_o  = top_eq && mid_eq && usable;

  assign pa_o = {lower_i[TOP_HI:TOP_LO],
                 (ea_mid & len_mask) | lower_i[MID_HI:MID_LO],
                 ea_i[MID_LO-1:0]};

  assign wr_ok_o = lower_i[RW_BIT];
  assign rd_ok_o = lower_i[RW_BIT] | lower_i[RO_BIT];

  assign unused_bits = ^{upper_i[MID_LO-1:MSK_HI+1], lower_i[MID_LO-1:RW_BIT+1]};
endmodule

// File: rtl/bat_prio_pick.sv
module bat_prio_pick
  import bat_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 4
) (
  input  logic [NUM_ENTRIES-1:0] match_i,
  input  word_t [NUM_ENTRIES-1:0] pa_i,
  input  logic [NUM_ENTRIES-1:0] rd_ok_i,
  input  logic [NUM_ENTRIES-1:0] wr_ok_i,
  output logic                   hit_o,
  output word_t                  pa_o,
  output logic                   rd_ok_o,
  output logic                   wr_ok_o
);
  // scan from highest to lowest so the lowest index overrides
  always_comb begin
    hit_o   = 1'b0;
    pa_o    = '0;
    rd_ok_o = 1'b0;
    wr_ok_o = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        hit_o   = 1'b1;
        pa_o    = pa_i[i];
        rd_ok_o = rd_ok_i[i];
        wr_ok_o = wr_ok_i[i];
      end
    end
  end
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
  import bat_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 4,
  parameter bit          REG_OUT     = 1'b1,
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      ea_i,
  input  logic             supervisor_i,
  input  logic             ifetch_i,
  input  logic             store_i,
  input  logic             cfg_we_i,
  input  logic             cfg_bank_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic             cfg_upper_i,
  input  logic [31:0]      cfg_wdata_i,
  output logic             hit_o,
  output logic [31:0]      pa_o,
  output logic             rd_ok_o,
  output logic             wr_ok_o,
  output logic             prot_fault_o
);
  word_t [NUM_ENTRIES-1:0] upr;
  word_t [NUM_ENTRIES-1:0] lwr;
  logic  [NUM_ENTRIES-1:0] ent_match;
  word_t [NUM_ENTRIES-1:0] ent_pa;
  logic  [NUM_ENTRIES-1:0] ent_rd;
  logic  [NUM_ENTRIES-1:0] ent_wr;
  logic                    sel_hit;
  word_t                   sel_pa;
  logic                    sel_rd;
  logic                    sel_wr;
  xlate_res_t              res_d;
  xlate_res_t              res_q;

  bat_regfile #(.NUM_ENTRIES(NUM_ENTRIES)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .wr_bank_i  (cfg_bank_i),
    .wr_idx_i   (cfg_idx_i),
    .wr_upper_i (cfg_upper_i),
    .wdata_i    (cfg_wdata_i),
    .rd_bank_i  (ifetch_i),
    .upper_o    (upr),
    .lower_o    (lwr)
  );

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cmp
    bat_entry_cmp u_cmp (
      .ea_i         (ea_i),
      .supervisor_i (supervisor_i),
      .upper_i      (upr[e]),
      .lower_i      (lwr[e]),
      .match_o      (ent_match[e]),
      .pa_o         (ent_pa[e]),
      .rd_ok_o      (ent_rd[e]),
      .wr_ok_o      (ent_wr[e])
    );
  end

  bat_prio_pick #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
    .match_i (ent_match),
    .pa_i    (ent_pa),
    .rd_ok_i (ent_rd),
    .wr_ok_i (ent_wr),
    .hit_o   (sel_hit),
    .pa_o    (sel_pa),
    .rd_ok_o (sel_rd),
    .wr_ok_o (sel_wr)
  );

  always_comb begin
    res_d.hit   = sel_hit;
    res_d.pa    = sel_pa;
    res_d.rd_ok = sel_rd;
    res_d.wr_ok = sel_wr;
    res_d.fault = sel_hit && (store_i ? !sel_wr : !sel_rd);
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) res_q <= '0;
      else         res_q <= res_d;
    end
  end else begin : g_comb
    assign res_q = res_d;
  end

  assign hit_o        = res_q.hit;
  assign pa_o         = res_q.pa;
  assign rd_ok_o      = res_q.rd_ok;
  assign wr_ok_o      = res_q.wr_ok;
  assign prot_fault_o = res_q.fault;
endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] ea_i,
  input logic        store_i,
  input logic        hit_o,
  input logic [31:0] pa_o,
  input logic        rd_ok_o,
  input logic        wr_ok_o,
  input logic        prot_fault_o
);
  p_fault_needs_hit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_fault_o |-> hit_o);

  p_miss_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (pa_o == 32'h0) && !rd_ok_o && !wr_ok_o && !prot_fault_o);

  p_write_implies_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok_o |-> rd_ok_o);

  if (REG_OUT) begin : g_reg
    p_low_bits_carry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o |-> pa_o[16:0] == $past(ea_i[16:0]));

    p_fault_verdict_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o |-> prot_fault_o == ($past(store_i) ? !wr_ok_o : !rd_ok_o));
  end else begin : g_comb
    p_low_bits_carry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o |-> pa_o[16:0] == ea_i[16:0]);

    p_fault_verdict_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_o |-> prot_fault_o == (store_i ? !wr_ok_o : !rd_ok_o));
  end
endmodule

bind bat_xlate bat_xlate_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ea_i         (ea_i),
  .store_i      (store_i),
  .hit_o        (hit_o),
  .pa_o         (pa_o),
  .rd_ok_o      (rd_ok_o),
  .wr_ok_o      (wr_ok_o),
  .prot_fault_o (prot_fault_o)
);

// File: tb/sim_bat_xlate.sv
module sim_bat_xlate;
  localparam int PERIOD = 10;
  localparam int NE     = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ea = '0;
  logic        sup = 1'b0, ifetch = 1'b0, store = 1'b0;
  logic        cfg_we = 1'b0, cfg_bank = 1'b0, cfg_upper = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        hit, rd_ok, wr_ok, fault;
  logic [31:0] pa;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] mup [2][NE];
  logic [31:0] mlo [2][NE];

  always #(PERIOD/2) clk = ~clk;

  bat_xlate u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ea_i(ea), .supervisor_i(sup),
    .ifetch_i(ifetch), .store_i(store), .cfg_we_i(cfg_we),
    .cfg_bank_i(cfg_bank), .cfg_idx_i(cfg_idx), .cfg_upper_i(cfg_upper),
    .cfg_wdata_i(cfg_wdata), .hit_o(hit), .pa_o(pa), .rd_ok_o(rd_ok),
    .wr_ok_o(wr_ok), .prot_fault_o(fault)
  );

  function automatic void finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endfunction

  // behavioural reference: first usable matching entry, by index
  task automatic model(output logic eh, output logic [31:0] epa,
                       output logic er, output logic ew, output logic ef);
    int b;
    b = ifetch ? 1 : 0;
    eh = 0; epa = 0; er = 0; ew = 0; ef = 0;
    for (int i = 0; i < NE; i++) begin
      logic [31:0] u, l;
      logic [10:0] m, mid;
      u = mup[b][i]; l = mlo[b][i];
      m = u[12:2]; mid = ea[27:17];
      if (ea[31:28] == u[31:28] && (mid & ~m) == u[27:17] &&
          (sup ? u[1] : u[0])) begin
        eh  = 1;
        epa = {l[31:28], (mid & m) | l[27:17], ea[16:0]};
        ew  = l[1];
        er  = l[1] | l[0];
        ef  = store ? !ew : !er;
        break;
      end
    end
  endtask

  task automatic step(input string tag);
    logic eh, er, ew, ef;
    logic [31:0] epa;
    @(posedge clk);
    model(eh, epa, er, ew, ef);
    if (cfg_we) begin
      if (cfg_upper) mup[cfg_bank][cfg_idx] = cfg_wdata;
      else           mlo[cfg_bank][cfg_idx] = cfg_wdata;
    end
    @(negedge clk);
    checks++;
    if (hit !== eh || pa !== epa || rd_ok !== er || wr_ok !== ew || fault !== ef) begin
      failures++;
      $display("FAIL %s ea=%h: hit/pa/rd/wr/flt act=%b/%h/%b/%b/%b exp=%b/%h/%b/%b/%b",
               tag, ea, hit, pa, rd_ok, wr_ok, fault, eh, epa, er, ew, ef);
    end
  endtask

  task automatic wr(input bit bank, input int idx, input bit upper,
                    input logic [31:0] d);
    cfg_we = 1; cfg_bank = bank; cfg_idx = 2'(idx); cfg_upper = upper; cfg_wdata = d;
    step("R8 cfg write, R11 lookup uses old contents");
    cfg_we = 0;
  endtask

  task automatic acc(input logic [31:0] a, input bit s, input bit f,
                     input bit w, input string tag);
    ea = a; sup = s; ifetch = f; store = w;
    step(tag);
  endtask

  initial begin
    #(PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < NE; i++) begin mup[b][i] = 0; mlo[b][i] = 0; end

    repeat (3) @(negedge clk);
    checks++;
    if (hit !== 0 || pa !== 0 || rd_ok !== 0 || wr_ok !== 0 || fault !== 0) begin
      failures++;
      $display("FAIL R9 in-reset outputs act=%b/%h exp=0/0", hit, pa);
    end
    rst_ni = 1;
    acc(32'h1001_2345, 1, 0, 0, "R9 empty data bank");
    acc(32'h0000_0000, 0, 1, 0, "R9 empty instr bank");

    // data entry 0: 128 KB at 0x1000_0000, supervisor only, read/write
    wr(0, 0, 1, 32'h1000_0002);
    wr(0, 0, 0, 32'h8000_0002);
    acc(32'h1001_2345, 1, 0, 0, "R3 R5 min block hit");
    acc(32'h1001_FFFF, 1, 0, 1, "R6 rw store ok");
    acc(32'h1002_0000, 1, 0, 0, "R3 min block edge miss R10");
    acc(32'h5001_2345, 1, 0, 0, "R2 top bits mismatch");
    acc(32'h1001_2345, 0, 0, 0, "R4 user on supervisor-only entry");

    // data entry 1: 256 MB at 0x2000_0000, both modes, read-only
    wr(0, 1, 1, 32'h2000_1FFF);
    wr(0, 1, 0, 32'h4000_0001);
    acc(32'h2ABC_DEF0, 0, 0, 0, "R3 R5 max block read");
    acc(32'h2FFF_FFFF, 1, 0, 1, "R7 store to read-only");
    acc(32'h3000_0000, 1, 0, 0, "R2 max block upper edge");

    // entries 2 and 3 overlap entry 0; entry 2 usable in user mode
    wr(0, 2, 1, 32'h1000_0003);
    wr(0, 2, 0, 32'h9000_0002);
    wr(0, 3, 1, 32'h1000_0003);
    wr(0, 3, 0, 32'hA000_0001);
    acc(32'h1000_0100, 1, 0, 0, "R1 entry 0 beats 2 and 3");
    acc(32'h1000_0100, 0, 0, 1, "R1 R4 user skips entry 0 picks 2");

    // no-access block
    wr(0, 3, 1, 32'h3000_0002);
    wr(0, 3, 0, 32'h5000_0000);
    acc(32'h3000_1000, 1, 0, 0, "R6 R7 no-access read fault");
    acc(32'h3000_1000, 1, 0, 1, "R7 no-access store fault");

    // bank separation
    acc(32'h1001_2345, 1, 1, 0, "R8 instr bank still empty");
    wr(1, 0, 1, 32'h1000_0001);
    wr(1, 0, 0, 32'hC000_0001);
    acc(32'h1001_2345, 0, 1, 0, "R8 instr bank hit");
    acc(32'h1001_2345, 0, 0, 0, "R8 data bank unaffected");

    // lookup in the same cycle as a write to the entry used
    ea = 32'h1001_2345; sup = 0; ifetch = 1; store = 0;
    wr(1, 0, 0, 32'hD000_0002);
    acc(32'h1001_2345, 0, 1, 1, "R11 new word seen next cycle");

    // mid-size block with masked-bit mismatch in upper word
    wr(0, 2, 1, 32'h6020_007F);   // mask 0x1F, but upper bit 21 set under mask
    wr(0, 2, 0, 32'h7000_0002);
    acc(32'h6020_0000, 1, 0, 0, "R3 upper bit under mask blocks match");

    // random mix
    for (int n = 0; n < 400; n++) begin
      if (($urandom % 4) == 0) begin
        logic [10:0] m, mid;
        logic [31:0] u;
        m = 11'((1 << ($urandom % 12)) - 1);
        mid = 11'($urandom) & ~m;
        u = {4'($urandom % 4 + 1), mid, 4'h0, m, 2'($urandom)};
        cfg_we = 1; cfg_bank = 1'($urandom); cfg_idx = 2'($urandom);
        cfg_upper = 1'($urandom);
        cfg_wdata = cfg_upper ? u : $urandom;
      end
      ea = {4'($urandom % 4 + 1), 28'($urandom)};
      if (($urandom % 2) == 0) ea[27:17] = 11'h0;
      sup = 1'($urandom); ifetch = 1'($urandom); store = 1'($urandom);
      step("R1 R5 R6 R7 R8 random");
      cfg_we = 0;
    end

    rst_ni = 0;
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < NE; i++) begin mup[b][i] = 0; mlo[b][i] = 0; end
    @(negedge clk);
    rst_ni = 1;
    acc(32'h1001_2345, 1, 0, 0, "R9 reset clears entries");
    finish_run();
  end
endmodule